// File: doc/BRIEF.md
# Per-Core Two-Stage Tick Timer

This block is one local timer, meant to be instantiated once per processor core. It chains two down-counters. The first is a prescaler. It divides the input clock by the programmed tick count plus one, and emits a single-cycle tick at each expiry. The second is an event counter. It consumes those ticks and raises an event once the programmed number of ticks has elapsed. The event sets a sticky status flag. That flag drives the interrupt output when the interrupt enable bit allows it.

Software programs the block through a small register window. A write to the event count buffer takes effect only when its update flag is set. Every write to the tick buffer, the event buffer or the control register raises its own write-acknowledge flag, which software clears. In interval mode the event counter reloads itself and events keep coming. With interval mode off, the counter stops at zero after one event and stays there until its start bit is cleared and set again. Placing several instances in the address map, routing interrupts to cores and adapting to a bus are left to the surrounding logic.

Top module: `tick_timer_core`

## Requirements
- R1: After reset, every readable register returns 0 and irq is low.
- R2: The register window decodes the offsets used by the interrupt path and the wider system:
  - 0x00 is the tick buffer (full 32 bits).
  - 0x08 is the event count buffer; bits 30:0 read back.
  - 0x20 is control. Bit 0 is tick run, bit 1 is event run and bit 2 is interval mode. Bits 2:0 read back.
  - 0x30 is status, bit 0.
  - 0x34 is interrupt enable, bit 0.
  - 0x40 is write-acknowledge.
  - Any other offset reads 0.
- R3: While control bit 0 is set, the prescaler ticks once every N+1 clocks, where N is the tick buffer value. While bit 0 is clear there are no ticks, and the prescaler reloads N.
- R4: Suppose one control write sets bits 0 and 1, the tick buffer holds N and the event buffer holds C (C ≥ 1). Then status bit 0 becomes visible exactly C*(N+1) clocks after the clock edge that accepted the write.
- R5: A write to offset 0x08 with bit 31 clear leaves the event count buffer unchanged. With bit 31 set, bits 30:0 are loaded into both the buffer and the event counter.
- R6: With control bit 2 set, events repeat every C*(N+1) clocks without further writes.
- R7: With control bit 2 clear, the event counter halts at zero after its event and raises no further events. Clearing control bit 1 and then setting it again restarts a full count.
- R8: Status bit 0 is set by an event and cleared by writing 1 to it. Writing 0 has no effect. An event in the same cycle as a clear wins.
- R9: irq is high exactly when status bit 0 and enable bit 0 are both set. The status bit still sets while enable is 0.
- R10: A write to 0x00, 0x08 or 0x20 sets write-acknowledge bit 0, 1 or 3 respectively on the next clock. Writing 1 to a bit at 0x40 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Byte offset of the write within the window |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the read within the window |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Interrupt request, status gated by enable |

## Verification
Several rules are checked on every cycle:
- ticks occur only while the prescaler runs;
- events occur only on a tick while the event counter runs;
- status rises only because of an event;
- a one-shot event leaves the event counter at zero;
- a control write always raises its acknowledge bit;
- irq never rises without an event or an enable write.

Some behaviour is visible only through the bench's timed scenarios:
- the exact C*(N+1) spacing across a sweep of small tick and event counts;
- the repeat spacing in interval mode;
- the silence after a one-shot event and the restart after it;
- the paused prescaler;
- the ignored buffer write.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_TICK_BUF = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_EVT_BUF  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CTRL     = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_STAT     = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_IEN      = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_WACK     = 8'h40;

  localparam int UPDATE_BIT = 31;
  localparam int WACK_TICK  = 0;
  localparam int WACK_EVT   = 1;
  localparam int WACK_CTRL  = 3;

  typedef struct packed {
    logic interval;
    logic evt_run;
    logic tick_run;
  } ctrl_t;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] reload,
  output logic         tick
);
  logic [W-1:0] cnt;

  function automatic logic [W-1:0] step(input logic [W-1:0] cur, input logic [W-1:0] rld);
    return (cur == '0) ? rld : cur - 1'b1;
  endfunction

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= reload;
    else           cnt <= step(cnt, reload);
  end
endmodule

// File: rtl/tt_event_counter.sv
module tt_event_counter #(
  parameter int W = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         interval,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload,
  output logic         evt,
  output logic         at_zero
);
  logic [W-1:0] cnt;

  function automatic logic [W-1:0] after_tick(input logic [W-1:0] cur, input logic [W-1:0] rld,
                                              input logic rep);
    if (cur == W'(1)) return rep ? rld : '0;
    return cur - 1'b1;
  endfunction

  assign at_zero = (cnt == '0);
  assign evt     = run && tick && (cnt == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (load)                   cnt <= load_val;
    else if (!run)                   cnt <= reload;
    else if (tick && cnt != '0)      cnt <= after_tick(cnt, reload, interval);
  end
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tick_timer_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int EVT_W  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              evt,
  output logic [TICK_W-1:0] tick_buf,
  output logic [EVT_W-1:0]  evt_buf,
  output logic              evt_load,
  output ctrl_t             ctrl,
  output logic              sts,
  output logic              ien,
  output logic              ws_ctrl,
  output logic [DATA_W-1:0] rd_data
);
  logic ws_tick, ws_evt;
  logic wr_tick, wr_evt, wr_ctrl, wr_stat, wr_ien, wr_wack;

  assign wr_tick  = wr_en && (wr_addr == OFF_TICK_BUF);
  assign wr_evt   = wr_en && (wr_addr == OFF_EVT_BUF);
  assign wr_ctrl  = wr_en && (wr_addr == OFF_CTRL);
  assign wr_stat  = wr_en && (wr_addr == OFF_STAT);
  assign wr_ien   = wr_en && (wr_addr == OFF_IEN);
  assign wr_wack  = wr_en && (wr_addr == OFF_WACK);
  assign evt_load = wr_evt && wr_data[UPDATE_BIT];

  function automatic logic ack_next(input logic cur, input logic set, input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_buf <= '0;
      evt_buf  <= '0;
      ctrl     <= '0;
      sts      <= 1'b0;
      ien      <= 1'b0;
      ws_tick  <= 1'b0;
      ws_evt   <= 1'b0;
      ws_ctrl  <= 1'b0;
    end else begin
      if (wr_tick)  tick_buf <= wr_data[TICK_W-1:0];
      if (evt_load) evt_buf  <= wr_data[EVT_W-1:0];
      if (wr_ctrl)  ctrl     <= ctrl_t'(wr_data[2:0]);
      if (wr_ien)   ien      <= wr_data[0];
      sts     <= evt ? 1'b1 : ((wr_stat && wr_data[0]) ? 1'b0 : sts);
      ws_tick <= ack_next(ws_tick, wr_tick, wr_wack && wr_data[WACK_TICK]);
      ws_evt  <= ack_next(ws_evt,  wr_evt,  wr_wack && wr_data[WACK_EVT]);
      ws_ctrl <= ack_next(ws_ctrl, wr_ctrl, wr_wack && wr_data[WACK_CTRL]);
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFF_TICK_BUF: rd_data = DATA_W'(tick_buf);
      OFF_EVT_BUF:  rd_data = DATA_W'(evt_buf);
      OFF_CTRL:     rd_data = DATA_W'(ctrl);
      OFF_STAT:     rd_data = DATA_W'(sts);
      OFF_IEN:      rd_data = DATA_W'(ien);
      OFF_WACK: begin
        rd_data[WACK_TICK] = ws_tick;
        rd_data[WACK_EVT]  = ws_evt;
        rd_data[WACK_CTRL] = ws_ctrl;
      end
      default:      rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_core.sv
module tick_timer_core
  import tick_timer_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int EVT_W  = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [TICK_W-1:0] tick_buf;
  logic [EVT_W-1:0]  evt_buf;
  logic              evt_load;
  ctrl_t             ctrl;
  logic              sts, ien, ws_ctrl;
  logic              tick, evt, icnt_zero;
  logic              tick_run, evt_run, interval_mode;

  assign tick_run      = ctrl.tick_run;
  assign evt_run       = ctrl.evt_run;
  assign interval_mode = ctrl.interval;

  tt_regs #(.TICK_W(TICK_W), .EVT_W(EVT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .evt(evt), .tick_buf(tick_buf), .evt_buf(evt_buf),
    .evt_load(evt_load), .ctrl(ctrl), .sts(sts), .ien(ien), .ws_ctrl(ws_ctrl),
    .rd_data(rd_data)
  );

  tt_prescaler #(.W(TICK_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(tick_run), .reload(tick_buf), .tick(tick)
  );

  tt_event_counter #(.W(EVT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .run(evt_run), .interval(interval_mode), .tick(tick),
    .load(evt_load), .load_val(wr_data[EVT_W-1:0]), .reload(evt_buf),
    .evt(evt), .at_zero(icnt_zero)
  );

  assign irq = sts && ien;
endmodule

// File: rtl/tick_timer_core_chk.sv
module tick_timer_core_chk
  import tick_timer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              tick,
  input logic              evt,
  input logic              tick_run,
  input logic              evt_run,
  input logic              interval_mode,
  input logic              evt_load,
  input logic              icnt_zero,
  input logic              sts,
  input logic              ws_ctrl,
  input logic              irq
);
  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> tick_run); // R3
  AST_EVENT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (tick && evt_run)); // R4
  AST_EVENT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> sts); // R8
  AST_STATUS_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts) |-> $past(evt)); // R8
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !interval_mode && !evt_load) |=> icnt_zero); // R7
  AST_CTRL_WACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFF_CTRL) |=> ws_ctrl); // R10
  AST_IRQ_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(evt) || $past(wr_en && wr_addr == OFF_IEN))); // R9
endmodule

bind tick_timer_core tick_timer_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .tick(tick), .evt(evt),
  .tick_run(tick_run), .evt_run(evt_run), .interval_mode(interval_mode),
  .evt_load(evt_load), .icnt_zero(icnt_zero), .sts(sts), .ws_ctrl(ws_ctrl), .irq(irq)
);

// File: tb/tick_timer_core_test.sv
module tick_timer_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  tick_timer_core uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      summary();
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic wait_irq(input int limit, output int n);
    n = 0;
    while (!irq && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic setup(input int n, input int c);
    wr(8'h20, 32'h0);
    wr(8'h00, n);
    wr(8'h08, 32'h8000_0000 | c);
    wr(8'h30, 32'h1);
    wr(8'h34, 32'h1);
  endtask

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irq, 0);
    foreach (d[i]) begin end
    rd(8'h00, d); check("R1 tick buf", d, 0);
    rd(8'h08, d); check("R1 evt buf", d, 0);
    rd(8'h20, d); check("R1 ctrl", d, 0);
    rd(8'h30, d); check("R1 status", d, 0);
    rd(8'h34, d); check("R1 enable", d, 0);
    rd(8'h40, d); check("R1 wack", d, 0);

    // R2 / R10 register map and acknowledge flags
    wr(8'h00, 32'hA5A5_1234);
    rd(8'h00, d); check("R2 tick buf", d, 32'hA5A5_1234);
    rd(8'h40, d); check("R10 wack tick", d, 32'h1);
    wr(8'h40, 32'h1);
    rd(8'h40, d); check("R10 wack clear", d, 32'h0);
    wr(8'h08, 32'h8000_0055);
    rd(8'h08, d); check("R2 evt buf", d, 32'h55);
    rd(8'h40, d); check("R10 wack evt", d, 32'h2);
    wr(8'h20, 32'hFFFF_FFF8);
    rd(8'h20, d); check("R2 ctrl", d, 32'h0);
    rd(8'h40, d); check("R10 wack ctrl", d, 32'hA);
    wr(8'h40, 32'hF);
    rd(8'h40, d); check("R10 wack clear all", d, 32'h0);
    wr(8'h34, 32'hFFFF_FFFE);
    rd(8'h34, d); check("R2 enable", d, 0);
    rd(8'h04, d); check("R2 unmapped", d, 0);
    wr(8'h30, 32'h1);
    rd(8'h40, d); check("R10 status write no ack", d, 32'h0);

    // R5 buffer write without update flag is ignored
    wr(8'h08, 32'h0000_0077);
    rd(8'h08, d); check("R5 no update", d, 32'h55);
    wr(8'h08, 32'h8000_0033);
    rd(8'h08, d); check("R5 update", d, 32'h33);

    // R3 R4 one-shot sweep, and R7 silence afterwards
    for (int nn = 0; nn < 4; nn++) begin
      for (int cc = 1; cc < 4; cc++) begin
        setup(nn, cc);
        wr(8'h20, 32'h3);
        wait_irq(100, n);
        check($sformatf("R4 R3 period N=%0d C=%0d", nn, cc), n, (nn + 1) * cc);
        wr(8'h30, 32'h1);
        repeat (3 * (nn + 1) * cc + 4) @(negedge clk);
        check($sformatf("R7 halt N=%0d C=%0d", nn, cc), irq, 0);
      end
    end

    // R6 interval mode repeats
    setup(2, 3);
    wr(8'h20, 32'h7);
    wait_irq(100, n);
    check("R6 first", n, 9);
    for (int k = 0; k < 3; k++) begin
      wr(8'h30, 32'h1);
      wait_irq(100, n);
      check("R6 repeat", n, 8);
    end

    // R7 restart after a one-shot event
    setup(1, 2);
    wr(8'h20, 32'h3);
    wait_irq(100, n);
    check("R7 first", n, 4);
    wr(8'h30, 32'h1);
    wr(8'h20, 32'h0);
    wr(8'h20, 32'h3);
    wait_irq(100, n);
    check("R7 restart", n, 4);

    // R9 enable gates irq; R8 write-1-to-clear
    setup(1, 2);
    wr(8'h34, 32'h0);
    wr(8'h20, 32'h3);
    repeat (8) @(negedge clk);
    check("R9 gated irq", irq, 0);
    rd(8'h30, d); check("R9 status set", d, 1);
    wr(8'h34, 32'h1);
    check("R9 irq on enable", irq, 1);
    wr(8'h30, 32'h0);
    rd(8'h30, d); check("R8 write 0 keeps", d, 1);
    wr(8'h30, 32'h1);
    rd(8'h30, d); check("R8 write 1 clears", d, 0);
    check("R8 irq low", irq, 0);

    // R3 prescaler paused: no ticks while bit 0 clear
    setup(1, 2);
    wr(8'h20, 32'h3);
    repeat (2) @(negedge clk);
    wr(8'h20, 32'h2);
    repeat (20) @(negedge clk);
    check("R3 paused", irq, 0);
    wr(8'h20, 32'h3);
    wait_irq(100, n);
    check("R3 resume", n, 2);

    summary();
  end
endmodule